// File: doc/BRIEF.md
# Burst-Limited Round-Robin Bus Arbiter

This block decides which of several DMA channels drives a shared memory bus. Each channel raises a request while it has work pending and reports whether its local buffer is full. The arbiter hands the bus to one requester at a time and keeps it there for a run of beats. It takes the bus back when the run reaches a programmed length, when the owner's buffer fills, or when the owner withdraws its request. Every hand-back is followed by one idle clock with no grant. The next owner is then chosen from a rotating starting point, so every requesting channel gets its turn.

The beat handshake behaves like a stream. `cyc_valid_o` is the valid side and `beat_ack_i` is the ready side. A beat is transferred only in a cycle where both are high. The bus slave applies back-pressure by holding `beat_ack_i` low. This stretches the current beat and does not count toward the burst. `cyc_valid_o` may fall without a transfer only when the owner loses its right to the bus (buffer full or request withdrawn). All other pins are plain control levels. Grant bit i belongs to channel i.

Top module: `burst_rr_arbiter`

## Requirements
- R1: `grant_o` has at most one bit set. A bit can only become set on a clock edge at which that channel's `req_i` bit was high. When no grant is held, a request seen at an edge produces the grant right after that edge.
- R2: The search for a new owner starts at the channel numbered one above the previous winner (wrapping from NUM_CH-1 to 0) and goes upward. After reset the search starts at channel 0.
- R3: `cyc_valid_o` is high exactly when a grant is held, the owner's `req_i` bit is high and the owner's `fifo_full_i` bit is low.
- R4: A beat is counted only in a cycle with `cyc_valid_o` and `beat_ack_i` both high. An acknowledge in any other cycle has no effect.
- R5: The burst length is taken from `burst_len_i` at the edge that issues the grant. A value of 0 acts as 1, and a value above MAX_BURST acts as MAX_BURST. Later changes to `burst_len_i` do not affect the running burst.
- R6: `last_beat_o` is high when `cyc_valid_o` is high and the owner has already completed length-1 beats of its burst.
- R7: After the final beat of a burst is acknowledged, `grant_o` is zero for exactly one cycle. Arbitration takes place at the end of that cycle.
- R8: If the owner's `fifo_full_i` is high, `cyc_valid_o` falls in the same cycle and the grant is removed at the next edge, followed by the one-cycle gap.
- R9: If the owner's `req_i` falls in the middle of a burst, `cyc_valid_o` falls in the same cycle and the grant is removed at the next edge, followed by the one-cycle gap.
- R10: A channel that is the only requester wins again after each gap.
- R11: With no request pending and no grant held, `grant_o` is zero and `cyc_valid_o` and `last_beat_o` are low.
- R12: While `rst_n` is low, `grant_o` is zero and `cyc_valid_o` and `last_beat_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_CH | Per-channel request (channel has work) |
| fifo_full_i | input | NUM_CH | Per-channel buffer-full flag |
| burst_len_i | input | $clog2(MAX_BURST)+1 | Programmed burst length in beats |
| beat_ack_i | input | 1 | Bus slave accepts the current beat |
| grant_o | output | NUM_CH | One-hot owner of the bus |
| cyc_valid_o | output | 1 | Bus cycle valid for the owner |
| last_beat_o | output | 1 | Current beat is the last of the burst |

## Verification
The bench goes after the edges of a burst:
- A lone requester cycling through grant, final beat and gap. A design that skipped the gap would keep the grant continuously; one that added an extra idle clock would lag the model by a cycle.
- Full and withdrawn requests in mid-burst. A design with the wrong response would either keep `cyc_valid_o` high on a stalled owner or hold the grant one cycle too long.
- Acknowledges outside valid cycles, burst lengths that change every clock, and the values 0 and above MAX_BURST. These expose counters that count stray acknowledges or lengths that are not latched and clamped.
- Dense multi-channel traffic. A rotation pointer that fails to advance or to wrap would show up as a grant given to the wrong channel.

// File: rtl/burst_arb_pkg.sv
package burst_arb_pkg;
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          any,
  output logic [IW-1:0] win_idx,
  output logic [N-1:0]  win_oh
);
  always_comb begin
    int j;
    any     = 1'b0;
    win_idx = '0;
    win_oh  = '0;
    for (int k = 0; k < N; k++) begin
      j = int'(start) + k;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any       = 1'b1;
        win_idx   = IW'(j);
        win_oh[j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int MAXB = 256,
  parameter int BW   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          inc,
  input  logic [BW-1:0] len_in,
  output logic          at_last
);
  logic [BW-1:0] cnt_q, len_q, eff_len;

  // Clamp the programmed length to the range 1..MAXB.
  always_comb begin
    if (len_in == '0)              eff_len = BW'(1);
    else if (len_in > BW'(MAXB))   eff_len = BW'(MAXB);
    else                           eff_len = len_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= BW'(1);
    end else if (load) begin
      cnt_q <= '0;
      len_q <= eff_len;
    end else if (inc) begin
      cnt_q <= cnt_q + BW'(1);
    end
  end

  assign at_last = (cnt_q == len_q - BW'(1));
endmodule

// File: rtl/burst_rr_arbiter.sv
module burst_rr_arbiter
  import burst_arb_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int MAX_BURST = 256
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CH-1:0]              req_i,
  input  logic [NUM_CH-1:0]              fifo_full_i,
  input  logic [$clog2(MAX_BURST):0]     burst_len_i,
  input  logic                           beat_ack_i,
  output logic [NUM_CH-1:0]              grant_o,
  output logic                           cyc_valid_o,
  output logic                           last_beat_o
);
  localparam int IW = idx_width(NUM_CH);
  localparam int BW = $clog2(MAX_BURST) + 1;

  logic          owning_q;
  logic [IW-1:0] owner_q, ptr_q, ptr_nxt;
  logic [NUM_CH-1:0] grant_q;

  logic          pick_any;
  logic [IW-1:0] pick_idx;
  logic [NUM_CH-1:0] pick_oh;
  logic          at_last, beat, release_now, take;

  rr_pick #(.N(NUM_CH), .IW(IW)) u_pick (
    .req     (req_i),
    .start   (ptr_q),
    .any     (pick_any),
    .win_idx (pick_idx),
    .win_oh  (pick_oh)
  );

  // Pointer step: free wrap when the channel count fills the index, compare otherwise.
  generate
    if ((1 << IW) == NUM_CH) begin : g_wrap_pow2
      assign ptr_nxt = pick_idx + IW'(1);
    end else begin : g_wrap_cmp
      assign ptr_nxt = (pick_idx == IW'(NUM_CH - 1)) ? '0 : pick_idx + IW'(1);
    end
  endgenerate

  assign cyc_valid_o = owning_q & req_i[owner_q] & ~fifo_full_i[owner_q];
  assign beat        = cyc_valid_o & beat_ack_i;
  assign last_beat_o = cyc_valid_o & at_last;
  assign release_now = owning_q & (~cyc_valid_o | (beat & at_last));
  assign take        = ~owning_q & pick_any;

  beat_counter #(.MAXB(MAX_BURST), .BW(BW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take),
    .inc     (beat & ~release_now),
    .len_in  (burst_len_i),
    .at_last (at_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owning_q <= 1'b0;
      owner_q  <= '0;
      ptr_q    <= '0;
      grant_q  <= '0;
    end else if (take) begin
      owning_q <= 1'b1;
      owner_q  <= pick_idx;
      ptr_q    <= ptr_nxt;
      grant_q  <= pick_oh;
    end else if (release_now) begin
      owning_q <= 1'b0;
      grant_q  <= '0;
    end
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/burst_rr_arbiter_chk.sv
module burst_rr_arbiter_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req_i,
  input logic [NUM_CH-1:0] fifo_full_i,
  input logic              beat_ack_i,
  input logic [NUM_CH-1:0] grant_o,
  input logic              cyc_valid_o,
  input logic              last_beat_o
);
  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R1
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o == '0) |=> (grant_o == '0 || (grant_o & $past(req_i)) != '0));

  // R3
  valid_needs_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid_o |-> ((grant_o & req_i & ~fifo_full_i) != '0));

  // R6
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat_o |-> cyc_valid_o);

  // R7
  gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat_o && beat_ack_i) |=> (grant_o == '0));

  // R8
  stall_drops_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o != '0) && !cyc_valid_o) |=> (grant_o == '0));

  // R7
  no_direct_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |=> (grant_o == '0 || $stable(grant_o)));

  // R11
  idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |=> (grant_o == '0));
endmodule

bind burst_rr_arbiter burst_rr_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .fifo_full_i (fifo_full_i),
  .beat_ack_i  (beat_ack_i),
  .grant_o     (grant_o),
  .cyc_valid_o (cyc_valid_o),
  .last_beat_o (last_beat_o)
);

// File: tb/burst_rr_arbiter_tb_top.sv
module burst_rr_arbiter_tb_top;
  localparam int N    = 4;
  localparam int MAXB = 8;
  localparam int BW   = $clog2(MAXB) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, full = '0;
  logic [BW-1:0] blen = BW'(4);
  logic          ack = 1'b0;
  logic [N-1:0]  grant;
  logic          cvalid, lastb;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R12";

  // Reference model state
  bit own_m;
  int owner_m, cnt_m, len_m, ptr_m;

  always #10 clk = ~clk;

  burst_rr_arbiter #(.NUM_CH(N), .MAX_BURST(MAXB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .fifo_full_i(full),
    .burst_len_i(blen), .beat_ack_i(ack),
    .grant_o(grant), .cyc_valid_o(cvalid), .last_beat_o(lastb));

  function automatic int clamp_len(input int v);
    if (v == 0) return 1;
    if (v > MAXB) return MAXB;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_m = 0; owner_m = 0; cnt_m = 0; len_m = 1; ptr_m = 0;
    end else if (!own_m) begin
      for (int k = 0; k < N; k++) begin
        int j;
        j = (ptr_m + k) % N;
        if (!own_m && req[j]) begin
          own_m = 1; owner_m = j; cnt_m = 0;
          len_m = clamp_len(int'(blen)); ptr_m = (j + 1) % N;
        end
      end
    end else begin
      if (!(req[owner_m] && !full[owner_m])) own_m = 0;
      else if (ack) begin
        if (cnt_m + 1 == len_m) own_m = 0;
        else cnt_m = cnt_m + 1;
      end
    end
  end

  task automatic check(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int eg, ev, el;
    eg = own_m ? (1 << owner_m) : 0;
    ev = (own_m && req[owner_m] && !full[owner_m]) ? 1 : 0;
    el = (ev != 0 && cnt_m == len_m - 1) ? 1 : 0;
    check(tag, "grant", int'(grant), eg);
    check(tag, "cyc_valid", int'(cvalid), ev);
    check(tag, "last_beat", int'(lastb), el);
  endtask

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] f,
                      input logic a, input logic [BW-1:0] l);
    @(negedge clk);
    req = r; full = f; ack = a; blen = l;
    #2;
    compare();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int gaps;
    // R12: outputs quiet during reset even with requests present
    req = '1; ack = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check("R12", "grant in reset", int'(grant), 0);
    check("R12", "valid in reset", int'(cvalid), 0);
    check("R12", "last in reset", int'(lastb), 0);
    req = '0; ack = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    tag = "R11";
    for (int i = 0; i < 5; i++) step('0, '0, 1'b1, BW'(3));

    // R10 / R7: lone requester, length 4, always acked: 4 owned + 1 gap
    tag = "R10";
    gaps = 0;
    for (int i = 0; i < 26; i++) begin
      step(4'b0100, '0, 1'b1, BW'(4));
      if (i > 0 && grant == '0) gaps++;
    end
    check("R7", "gap cycles in 25", gaps, 5);

    tag = "R2";
    for (int i = 0; i < 40; i++) step('1, '0, 1'b1, BW'(3));
    for (int i = 0; i < 40; i++) step(4'b1010, '0, 1'b1, BW'(2));

    tag = "R4";
    for (int i = 0; i < 60; i++) step(4'b1010, '0, 1'($urandom_range(1)), BW'(3));

    tag = "R5";
    for (int i = 0; i < 80; i++)
      step(4'b0111, '0, 1'($urandom_range(3) != 0), BW'($urandom_range(15)));

    tag = "R8";
    for (int i = 0; i < 80; i++)
      step('1, N'($urandom_range(15) & $urandom_range(15)), 1'b1, BW'(5));

    tag = "R9";
    for (int i = 0; i < 80; i++)
      step(N'($urandom_range(15) | $urandom_range(15)), '0, 1'($urandom_range(1)), BW'(6));

    tag = "R6";
    for (int i = 0; i < 40; i++) step(4'b1001, '0, 1'($urandom_range(1)), BW'(1));

    tag = "R1";
    for (int i = 0; i < 2000; i++)
      step(N'($urandom_range(15)), N'($urandom_range(15) & $urandom_range(15) & $urandom_range(15)),
           1'($urandom_range(1)), BW'($urandom_range(15)));

    tag = "R3";
    for (int i = 0; i < 400; i++)
      step(N'($urandom_range(15)), N'($urandom_range(15) & $urandom_range(15)),
           1'($urandom_range(3) != 0), BW'($urandom_range(9)));

    tag = "R11";
    for (int i = 0; i < 4; i++) step('0, '0, 1'b1, BW'(2));
    check("R11", "grant idle end", int'(grant), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule